// File: doc/BRIEF.md
# Ethernet Transmit Outcome Recorder

This block sits beside the transmit engine of a 10/100 Ethernet MAC that runs in half or full duplex. For each frame it collects the events the engine reports: collisions, deferrals, a late collision, loss of carrier, a FIFO underrun and bus errors. It records them in a 32-bit status word. The outcome fields of that word change only at the end of a frame, whether the frame was sent or given up. Between frames software can read a stable summary of the last attempt.

The block counts the collisions of the frame in progress. It compares that count with a programmable retry limit. When the limit is exceeded it raises a one-cycle request that the engine abandon the frame. Deferral results are dropped in full duplex, where they mean nothing. A bus error sets a sticky fatal flag that shuts off all bus access until reset, or until software writes zero to that flag.

Top module: `txstat_collector`

## Requirements
- R1: While reset is held, and on the first cycle after it, `status_word`, `rd_data`, `excol_abort` and `bus_disable` are all zero.
- R2: Bits 14:0 of `status_word` are rewritten only on the clock edge that samples `frm_done` or `frm_abort` high. Events sampled on that same edge are included. At all other times these bits hold, including when events arrive outside a frame.
- R3: Bit 10 is set after a completion with a good outcome (bit 0) in which exactly one collision was counted.
- R4: Bit 9 is set after a completion with a good outcome in which two or more collisions were counted. Bits 10 and 9 are never both set.
- R5: The collision count clears on `frm_start`. The cycle after the collision that first makes the count exceed `retry_limit`, `excol_abort` is high for one cycle, once per frame. At completion, bit 8 records whether the count exceeded the limit.
- R6: In half duplex (`full_duplex` low at completion), bit 11 records a deferral and bit 12 records an excessive-deferral abort. With `full_duplex` high both bits read zero, and excessive deferral does not spoil the outcome.
- R7: Bits 14:13 hold `frm_type` as sampled with `frm_start`. The codes are 00 plain Ethernet framing, 01 802.2 LLC framing, 10 VLAN tagged type I and 11 VLAN tagged type II.
- R8: Bit 7 records a late collision, bit 6 a loss of carrier and bit 4 an underrun seen during the frame.
- R9: Bit 0 (good) is set only when the completion strobe was `frm_done` and none of these occurred: the `frm_abort` strobe, excessive collisions, excessive deferral in half duplex, a late collision or an underrun. Loss of carrier does not clear it.
- R10: Bit 31 and `bus_disable` go high the cycle after `bus_err_pulse`. They stay high until reset or a write (`sw_wr`) with `wr_fatal_val` = 0. Writing 1 has no effect, and a bus error in the same cycle as a clearing write wins.
- R11: Bits 27:15, 5 and 3:1 always read zero.
- R12: Bits 30:28 read 101 from the cycle after `frm_start` until the completion edge, and 000 otherwise.
- R13: `rd_data` shows the status word one cycle after `rd_en` is high, and is zero in the cycle after `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_start | input | 1 | Pulse: a new frame begins |
| frm_done | input | 1 | Pulse: frame fully sent |
| frm_abort | input | 1 | Pulse: frame given up on an error |
| frm_type | input | 2 | Encapsulation code, sampled with frm_start |
| col_pulse | input | 1 | One collision |
| defer_pulse | input | 1 | Frame was deferred |
| exdefer_pulse | input | 1 | Excessive deferral abort |
| late_col_pulse | input | 1 | Late collision |
| car_loss_pulse | input | 1 | Carrier lost during transmission |
| underrun_pulse | input | 1 | Transmit FIFO underrun |
| bus_err_pulse | input | 1 | Fatal bus error |
| full_duplex | input | 1 | 1 = full duplex |
| retry_limit | input | RETRY_W | Collisions allowed before abort |
| sw_wr | input | 1 | Software write strobe |
| wr_fatal_val | input | 1 | Value written to bit 31 (only 0 acts) |
| rd_en | input | 1 | Read request |
| status_word | output | 32 | Live status word |
| rd_data | output | 32 | Registered read data |
| excol_abort | output | 1 | One-cycle request to abandon the frame |
| bus_disable | output | 1 | Bus access shut off |

## Verification
The hardest situation to reach is a collision count that crosses the retry limit exactly once. Further collisions must then raise no second request, and the next frame must start from a fresh count. The stimulus runs a frame with limit 2 and four collisions, checks the request line after every single collision, and then runs a one-collision frame that must report a single collision rather than several. A limit of zero covers the edge where the very first collision already exceeds the limit. Events are also placed on the completion edge itself, and stray pulses are sent between frames, to show that fields are captured and held at the right moment.

// File: rtl/txstat_pkg.sv
// Package: shared bit positions, phase codes and the per-frame event flag type
// for the transmit outcome recorder. Assumes a 32-bit status word.
package txstat_pkg;
    localparam int unsigned STAT_W   = 32;
    localparam int unsigned OUT_W    = 15;   // outcome field, bits 14:0
    localparam int unsigned B_FATAL  = 31;
    localparam int unsigned B_TYPE   = 13;   // 2-bit field at 14:13
    localparam int unsigned B_EXDEF  = 12;
    localparam int unsigned B_DEF    = 11;
    localparam int unsigned B_SCOL   = 10;
    localparam int unsigned B_MCOL   = 9;
    localparam int unsigned B_EXCOL  = 8;
    localparam int unsigned B_LCOL   = 7;
    localparam int unsigned B_LCAR   = 6;
    localparam int unsigned B_UND    = 4;
    localparam int unsigned B_GOOD   = 0;

    typedef enum logic [2:0] {
        PH_IDLE = 3'b000,
        PH_RUN  = 3'b101
    } phase_e;

    typedef struct packed {
        logic exdef;
        logic def;
        logic lcol;
        logic lcar;
        logic und;
    } evflags_t;
endpackage

// File: rtl/txstat_colcnt.sv
// Module: per-frame collision counter with retry-limit comparison.
// Assumes frm_start never coincides with a collision that must be counted.
// Outputs the next-state count and exceed flag so a completion on the same
// edge sees the collision sampled there.
module txstat_colcnt #(
    parameter int unsigned RETRY_W = 4,
    localparam int unsigned CNT_W  = RETRY_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_start,
    input  logic               col_pulse,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic [CNT_W-1:0]   cnt_nxt,
    output logic               exc_nxt,
    output logic               abort_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             exc_q;
    logic             hit;

    // next count, exceed flag and first-crossing detect
    always_comb begin
        cnt_nxt = cnt_q;
        exc_nxt = exc_q;
        hit     = 1'b0;
        if (frm_start) begin
            cnt_nxt = '0;
            exc_nxt = 1'b0;
        end else if (col_pulse) begin
            if (cnt_q != {CNT_W{1'b1}}) begin
                cnt_nxt = cnt_q + 1'b1;
            end
            if ((cnt_nxt > CNT_W'(retry_limit)) && !exc_q) begin
                exc_nxt = 1'b1;
                hit     = 1'b1;
            end
        end
    end

    // state registers and the one-cycle abort request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            exc_q     <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            cnt_q     <= cnt_nxt;
            exc_q     <= exc_nxt;
            abort_req <= hit;
        end
    end
endmodule

// File: rtl/txstat_evacc.sv
// Module: accumulates deferral, late collision, carrier loss and underrun
// events for the frame in progress and latches the encapsulation code.
// Assumes events on the frm_start edge belong to no frame and are dropped.
module txstat_evacc
    import txstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frm_start,
    input  logic [1:0] frm_type,
    input  logic     defer_pulse,
    input  logic     exdefer_pulse,
    input  logic     late_col_pulse,
    input  logic     car_loss_pulse,
    input  logic     underrun_pulse,
    output evflags_t flags_nxt,
    output logic [1:0] type_q
);
    evflags_t flags_q;

    // merge this cycle's events into the frame's flags
    always_comb begin
        if (frm_start) begin
            flags_nxt = '0;
        end else begin
            flags_nxt.exdef = flags_q.exdef | exdefer_pulse;
            flags_nxt.def   = flags_q.def   | defer_pulse;
            flags_nxt.lcol  = flags_q.lcol  | late_col_pulse;
            flags_nxt.lcar  = flags_q.lcar  | car_loss_pulse;
            flags_nxt.und   = flags_q.und   | underrun_pulse;
        end
    end

    // hold flags and capture the frame type at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            type_q  <= 2'b00;
        end else begin
            flags_q <= flags_nxt;
            if (frm_start) begin
                type_q <= frm_type;
            end
        end
    end
endmodule

// File: rtl/txstat_fatal.sv
// Module: sticky fatal bus error flag. Set by a bus error, cleared only by
// reset or a software write of zero; a bus error beats a clearing write.
module txstat_fatal (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_err_pulse,
    input  logic sw_wr,
    input  logic wr_fatal_val,
    output logic fatal_q
);
    // set-dominant sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fatal_q <= 1'b0;
        end else if (bus_err_pulse) begin
            fatal_q <= 1'b1;
        end else if (sw_wr && !wr_fatal_val) begin
            fatal_q <= 1'b0;
        end
    end
endmodule

// File: rtl/txstat_collector.sv
// Module: top of the transmit outcome recorder. Commits the frame outcome
// into the status word on frm_done or frm_abort, tracks the in-frame phase,
// and offers a registered read port. Assumes frm_start and a completion
// strobe never share a cycle.
module txstat_collector
    import txstat_pkg::*;
#(
    parameter int unsigned RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_start,
    input  logic               frm_done,
    input  logic               frm_abort,
    input  logic [1:0]         frm_type,
    input  logic               col_pulse,
    input  logic               defer_pulse,
    input  logic               exdefer_pulse,
    input  logic               late_col_pulse,
    input  logic               car_loss_pulse,
    input  logic               underrun_pulse,
    input  logic               bus_err_pulse,
    input  logic               full_duplex,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               sw_wr,
    input  logic               wr_fatal_val,
    input  logic               rd_en,
    output logic [31:0]        status_word,
    output logic [31:0]        rd_data,
    output logic               excol_abort,
    output logic               bus_disable
);
    localparam int unsigned CNT_W = RETRY_W + 1;
    localparam int unsigned RSV_W = B_FATAL - 3 - OUT_W;

    logic [CNT_W-1:0] cnt_nxt;
    logic             exc_nxt;
    evflags_t         flags_nxt;
    logic [1:0]       type_q;
    logic             fatal_q;
    logic             commit;
    logic             half;
    logic             exdef_eff;
    logic             def_eff;
    logic             good;
    logic [OUT_W-1:0] outcome_d;
    logic [OUT_W-1:0] outcome_q;
    phase_e           phase_q;

    txstat_colcnt #(.RETRY_W(RETRY_W)) u_colcnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_start   (frm_start),
        .col_pulse   (col_pulse),
        .retry_limit (retry_limit),
        .cnt_nxt     (cnt_nxt),
        .exc_nxt     (exc_nxt),
        .abort_req   (excol_abort)
    );

    txstat_evacc u_evacc (
        .clk            (clk),
        .rst_n          (rst_n),
        .frm_start      (frm_start),
        .frm_type       (frm_type),
        .defer_pulse    (defer_pulse),
        .exdefer_pulse  (exdefer_pulse),
        .late_col_pulse (late_col_pulse),
        .car_loss_pulse (car_loss_pulse),
        .underrun_pulse (underrun_pulse),
        .flags_nxt      (flags_nxt),
        .type_q         (type_q)
    );

    txstat_fatal u_fatal (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_err_pulse (bus_err_pulse),
        .sw_wr         (sw_wr),
        .wr_fatal_val  (wr_fatal_val),
        .fatal_q       (fatal_q)
    );

    assign commit = frm_done | frm_abort;
    assign half   = ~full_duplex;

    // build the outcome field from the merged frame state
    always_comb begin
        exdef_eff = flags_nxt.exdef & half;
        def_eff   = flags_nxt.def & half;
        good      = frm_done & ~frm_abort & ~exc_nxt & ~exdef_eff
                  & ~flags_nxt.lcol & ~flags_nxt.und;
        outcome_d                  = '0;
        outcome_d[B_TYPE +: 2]     = type_q;
        outcome_d[B_EXDEF]         = exdef_eff;
        outcome_d[B_DEF]           = def_eff;
        outcome_d[B_SCOL]          = good && (cnt_nxt == CNT_W'(1));
        outcome_d[B_MCOL]          = good && (cnt_nxt >= CNT_W'(2));
        outcome_d[B_EXCOL]         = exc_nxt;
        outcome_d[B_LCOL]          = flags_nxt.lcol;
        outcome_d[B_LCAR]          = flags_nxt.lcar;
        outcome_d[B_UND]           = flags_nxt.und;
        outcome_d[B_GOOD]          = good;
    end

    // commit the outcome at frame completion, track the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome_q <= '0;
            phase_q   <= PH_IDLE;
        end else begin
            if (commit) begin
                outcome_q <= outcome_d;
                phase_q   <= PH_IDLE;
            end else if (frm_start) begin
                phase_q   <= PH_RUN;
            end
        end
    end

    assign status_word = {fatal_q, phase_q, {RSV_W{1'b0}}, outcome_q};
    assign bus_disable = fatal_q;

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? status_word : '0;
        end
    end
endmodule

// File: rtl/txstat_collector_chk.sv
// Checker: temporal properties of the transmit outcome recorder, bound to
// the top module.
module txstat_collector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_done,
    input logic        frm_abort,
    input logic        full_duplex,
    input logic        bus_err_pulse,
    input logic        sw_wr,
    input logic        wr_fatal_val,
    input logic        rd_en,
    input logic [31:0] status_word,
    input logic [31:0] rd_data,
    input logic        excol_abort,
    input logic        bus_disable
);
    // R4
    col_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_word[10] && status_word[9]));

    // R6
    fd_defer_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done || frm_abort) && full_duplex |=> status_word[12:11] == 2'b00);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[27:15] == 13'd0 && status_word[5] == 1'b0 && status_word[3:1] == 3'd0);

    // R10
    fatal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_pulse |=> bus_disable && status_word[31]);

    // R10
    fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_disable && !(sw_wr && !wr_fatal_val) |=> bus_disable);

    // R2
    outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_done || frm_abort) |=> $stable(status_word[14:0]));

    // R9
    good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_word[0] && (status_word[8] || status_word[7] || status_word[4])));

    // R5
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        excol_abort |=> !excol_abort);

    // R13
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 32'd0);
endmodule

bind txstat_collector txstat_collector_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_done      (frm_done),
    .frm_abort     (frm_abort),
    .full_duplex   (full_duplex),
    .bus_err_pulse (bus_err_pulse),
    .sw_wr         (sw_wr),
    .wr_fatal_val  (wr_fatal_val),
    .rd_en         (rd_en),
    .status_word   (status_word),
    .rd_data       (rd_data),
    .excol_abort   (excol_abort),
    .bus_disable   (bus_disable)
);

// File: tb/txstat_collector_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for the transmit outcome recorder. The frame driver
// pushes the expected status word; a monitor pops it at each completion.
module txstat_collector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 0, frm_done = 0, frm_abort = 0;
    logic [1:0]  frm_type = 2'b00;
    logic        col_pulse = 0, defer_pulse = 0, exdefer_pulse = 0;
    logic        late_col_pulse = 0, car_loss_pulse = 0, underrun_pulse = 0;
    logic        bus_err_pulse = 0, full_duplex = 0;
    logic [3:0]  retry_limit = 4'd4;
    logic        sw_wr = 0, wr_fatal_val = 1;
    logic        rd_en = 0;
    logic [31:0] status_word, rd_data;
    logic        excol_abort, bus_disable;

    int total = 0;
    int bad = 0;
    logic fatal_exp = 1'b0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    txstat_collector #(.RETRY_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_done(frm_done),
        .frm_abort(frm_abort), .frm_type(frm_type), .col_pulse(col_pulse),
        .defer_pulse(defer_pulse), .exdefer_pulse(exdefer_pulse),
        .late_col_pulse(late_col_pulse), .car_loss_pulse(car_loss_pulse),
        .underrun_pulse(underrun_pulse), .bus_err_pulse(bus_err_pulse),
        .full_duplex(full_duplex), .retry_limit(retry_limit), .sw_wr(sw_wr),
        .wr_fatal_val(wr_fatal_val), .rd_en(rd_en), .status_word(status_word),
        .rd_data(rd_data), .excol_abort(excol_abort), .bus_disable(bus_disable)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare the committed word against the scoreboard (R2)
    always @(posedge clk) begin
        if (rst_n && (frm_done || frm_abort)) begin
            #2;
            if (exp_q.size() == 0) begin
                chk("R2 scoreboard empty", 32'd1, 32'd0);
            end else begin
                chk("R2 committed word", status_word, exp_q.pop_front());
            end
        end
    end

    // driver: one frame, expected word pushed before the completion edge
    task automatic run_frame(input logic [1:0] ft, input int ncol, input logic dfr,
                             input logic exd, input logic lc, input logic lcr,
                             input logic ud, input logic fd, input logic [3:0] lim,
                             input logic ab, input logic evlast);
        logic [31:0] e;
        logic exc, exd_e, dfr_e, good;
        @(posedge clk); #1;
        frm_start = 1; frm_type = ft; retry_limit = lim; full_duplex = fd;
        @(posedge clk); #1;
        frm_start = 0; frm_type = 2'b00;
        chk("R12 running phase", {29'd0, status_word[30:28]}, 32'd5);
        for (int i = 1; i <= ncol; i++) begin
            col_pulse = 1;
            @(posedge clk); #1;
            col_pulse = 0;
            chk("R5 abort request", {31'd0, excol_abort}, {31'd0, (i == int'(lim) + 1)});
        end
        defer_pulse = dfr; exdefer_pulse = exd; late_col_pulse = lc;
        car_loss_pulse = lcr; underrun_pulse = ud;
        if (!evlast) begin
            @(posedge clk); #1;
            defer_pulse = 0; exdefer_pulse = 0; late_col_pulse = 0;
            car_loss_pulse = 0; underrun_pulse = 0;
        end
        exc   = ncol > int'(lim);
        exd_e = exd & ~fd;
        dfr_e = dfr & ~fd;
        good  = ~ab & ~exc & ~exd_e & ~lc & ~ud;
        e = 32'd0;
        e[31] = fatal_exp;
        e[14:13] = ft;
        e[12] = exd_e;
        e[11] = dfr_e;
        e[10] = good && ncol == 1;
        e[9]  = good && ncol >= 2;
        e[8]  = exc;
        e[7]  = lc;
        e[6]  = lcr;
        e[4]  = ud;
        e[0]  = good;
        exp_q.push_back(e);
        frm_done = ~ab; frm_abort = ab;
        @(posedge clk); #1;
        frm_done = 0; frm_abort = 0;
        defer_pulse = 0; exdefer_pulse = 0; late_col_pulse = 0;
        car_loss_pulse = 0; underrun_pulse = 0;
        chk("R12 idle phase", {29'd0, status_word[30:28]}, 32'd0);
        chk("R11 reserved zero", {19'd0, status_word[27:15]}, 32'd0);
    endtask

    // watchdog
    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 status in reset", status_word, 32'd0);
        chk("R1 outputs in reset", {29'd0, excol_abort, bus_disable, 1'b0}, 32'd0);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1 status after reset", status_word, 32'd0);
        chk("R1 rd_data after reset", rd_data, 32'd0);

        // R7 R9: clean frame, plain Ethernet
        run_frame(2'b00, 0, 0, 0, 0, 0, 0, 0, 4'd4, 0, 0);
        // R3 R6 R7: one collision, deferred, half duplex, LLC
        run_frame(2'b01, 1, 1, 0, 0, 0, 0, 0, 4'd4, 0, 0);
        // R4 R6: three collisions, full duplex hides deferral bits
        run_frame(2'b10, 3, 1, 1, 0, 0, 0, 1, 4'd4, 0, 0);
        // R5: limit 2, four collisions, engine gives up
        run_frame(2'b11, 4, 0, 0, 0, 0, 0, 0, 4'd2, 1, 0);
        // R5: limit 0, first collision exceeds
        run_frame(2'b00, 1, 0, 0, 0, 0, 0, 0, 4'd0, 1, 0);
        // R5 R3: count cleared at start, single collision again
        run_frame(2'b01, 1, 0, 0, 0, 0, 0, 0, 4'd4, 0, 0);
        // R6 R9: excessive deferral in half duplex spoils outcome
        run_frame(2'b00, 0, 0, 1, 0, 0, 0, 0, 4'd4, 0, 0);
        // R8 R2: late collision, carrier loss, underrun on the completion edge
        run_frame(2'b10, 0, 0, 0, 1, 1, 1, 0, 4'd4, 0, 1);
        // R8 R9: carrier loss alone keeps the frame good
        run_frame(2'b11, 2, 0, 0, 0, 1, 0, 0, 4'd4, 0, 0);
        // R9: abort strobe with no events
        run_frame(2'b00, 0, 0, 0, 0, 0, 0, 0, 4'd4, 1, 0);

        // R2: stray events between frames leave the word untouched
        held = status_word;
        col_pulse = 1; late_col_pulse = 1; underrun_pulse = 1;
        @(posedge clk); #1;
        col_pulse = 0; late_col_pulse = 0; underrun_pulse = 0;
        @(posedge clk); #1;
        chk("R2 hold between frames", status_word, held);

        // R10: bus error sets fatal flag and bus_disable
        bus_err_pulse = 1;
        @(posedge clk); #1;
        bus_err_pulse = 0;
        fatal_exp = 1;
        chk("R10 fatal set", {30'd0, status_word[31], bus_disable}, 32'd3);
        sw_wr = 1; wr_fatal_val = 1;
        @(posedge clk); #1;
        sw_wr = 0;
        chk("R10 write one ignored", {31'd0, bus_disable}, 32'd1);
        run_frame(2'b01, 0, 0, 0, 0, 0, 0, 0, 4'd4, 0, 0);
        sw_wr = 1; wr_fatal_val = 0; bus_err_pulse = 1;
        @(posedge clk); #1;
        sw_wr = 0; bus_err_pulse = 0;
        chk("R10 error beats clear", {31'd0, bus_disable}, 32'd1);
        sw_wr = 1; wr_fatal_val = 0;
        @(posedge clk); #1;
        sw_wr = 0; wr_fatal_val = 1;
        fatal_exp = 0;
        chk("R10 cleared by write", {30'd0, status_word[31], bus_disable}, 32'd0);

        // R13: read port
        held = status_word;
        rd_en = 1;
        @(posedge clk); #1;
        rd_en = 0;
        chk("R13 read data", rd_data, held);
        @(posedge clk); #1;
        chk("R13 idle read zero", rd_data, 32'd0);

        @(posedge clk); #1;
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule